// File: doc/BRIEF.md
# Status Register Write Controller

This unit keeps two 32-bit status words for a processor core: the live (current) status register and one saved copy. An execute stage hands it an instruction word, the value of a general register, a flag choosing the current or the saved word, and a flag saying whether the core runs unprivileged. On a read, the selected word appears whole on the read-data output. On a write, the new data is either the register operand or an 8-bit immediate rotated right. Only the bytes enabled by field-select bits in the instruction are merged in, and the privilege state adds a further limit.

Flag bits can be written at all times. Interrupt-disable and mode bits can be written only when the core is privileged. Any mode value written always has bit 4 set. The saved word takes a wider mask and does not check privilege. A write to the current word can change the execution state, so each one is followed by a one-cycle request to refetch the pipeline.

Top module: `stat_reg_ctrl`

## Requirements
- R1: When reset is released, the current word is 0x000000D3, the saved word is 0x00000010 and the refetch request is low.
- R2: When instr[25]=1, the write data is instr[7:0] rotated right by 2*instr[11:8]. When instr[25]=0, the write data is reg_operand. src_index always equals instr[3:0].
- R3: instr[19] enables the flag byte and instr[16] enables the control byte. Setting only instr[18:17] or instr[15:0] does not change either word.
- R4: On a current-word write with the flag byte enabled, current bits 31:28 take the data bits 31:28. Bits 27:8 of the current word never change.
- R5: On a current-word write with the control byte enabled, current bit 5 takes data bit 5, whether or not the core is privileged.
- R6: On a current-word write with the control byte enabled and priv_user=0, current bits 7:6 and 3:0 take the data bits and bit 4 is set. With priv_user=1, those bits keep their value. Current bit 4 is always 1.
- R7: A saved-word write replaces bits 31:28 when instr[19]=1 and bits 7:5 and 3:0 when instr[16]=1. Bit 4 is set on every such write, even with no field enabled.
- R8: rd_data is the whole saved word when op_saved=1 and the whole current word otherwise. It follows the select input in the same cycle.
- R9: refetch is high for exactly the one cycle after each current-word write, whatever fields are enabled. It stays low after saved-word writes, after reads and in idle cycles.
- R10: A write takes effect at the next clock edge. With op_valid=0, or on a read, neither word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_write | input | 1 | 1 for a write, 0 for a read |
| op_saved | input | 1 | 1 to target the saved word, 0 for the current word |
| priv_user | input | 1 | Core is running unprivileged |
| instr | input | 32 | Instruction word carrying the field enables, the form bit and the immediate |
| reg_operand | input | 32 | Value of the register named by src_index |
| src_index | output | 4 | Register index taken from the instruction |
| cur_q | output | 32 | Current status word |
| sav_q | output | 32 | Saved status word |
| rd_data | output | 32 | Selected word for reads |
| refetch | output | 1 | One-cycle pipeline refetch request |

## Verification
The bench covers the following corner cases:
- **Unprivileged control writes.** A design that ignores privilege lets an unprivileged core change its own mode or unmask interrupts.
- **A written mode of all zeros.** Without the forced bit 4, this leaves an invalid mode in the register.
- **Flag-byte writes with all ones.** A byte-wide merge corrupts bits 27:24.
- **Writes with no field enabled.** These must still pulse refetch on the current word and still set bit 4 of the saved word.
- **Immediates with zero and with maximum rotation.** Each one pins the rotate amount and direction.
- **Random operations checked every cycle.** A long run compared against a reference model catches a refetch tied to the wrong target or held too long.

// File: rtl/stat_reg_pkg.sv
package stat_reg_pkg;

    localparam int SR_W      = 32;
    localparam int IMM_W     = 8;
    localparam int ROT_W     = 4;
    localparam int IDX_W     = 4;

    // instruction bit positions that neighbouring decode depends on
    localparam int B_IMM_FORM = 25;
    localparam int B_FLAG_EN  = 19;
    localparam int B_CTRL_EN  = 16;

    // status word field masks
    localparam logic [SR_W-1:0] M_FLAGS   = 32'hF000_0000;
    localparam logic [SR_W-1:0] M_STATE   = 32'h0000_0020;
    localparam logic [SR_W-1:0] M_PRIV    = 32'h0000_00CF;
    localparam logic [SR_W-1:0] M_MODE4   = 32'h0000_0010;

    typedef struct packed {
        logic wr_cur;
        logic wr_sav;
        logic flag_en;
        logic ctrl_en;
        logic user;
    } sr_cmd_t;

    function automatic logic [SR_W-1:0] rot_imm(input logic [IMM_W-1:0] v,
                                                  input logic [ROT_W-1:0] r);
        logic [SR_W-1:0] z;
        logic [5:0]      amt;
        z   = {{(SR_W-IMM_W){1'b0}}, v};
        amt = {1'b0, r, 1'b0};
        return (z >> amt) | (z << (6'd32 - amt));
    endfunction

    function automatic logic [SR_W-1:0] cur_mask(input sr_cmd_t c);
        logic [SR_W-1:0] m;
        m = '0;
        if (c.flag_en) m = m | M_FLAGS;
        if (c.ctrl_en) begin
            m = m | M_STATE;
            if (!c.user) m = m | M_PRIV;
        end
        return m;
    endfunction

    function automatic logic [SR_W-1:0] sav_mask(input sr_cmd_t c);
        logic [SR_W-1:0] m;
        m = '0;
        if (c.flag_en) m = m | M_FLAGS;
        if (c.ctrl_en) m = m | M_STATE | M_PRIV;
        return m;
    endfunction

endpackage

// File: rtl/sr_decode.sv
module sr_decode
    import stat_reg_pkg::*;
(
    input  logic            op_valid,
    input  logic            op_write,
    input  logic            op_saved,
    input  logic            priv_user,
    input  logic [SR_W-1:0] instr,
    output sr_cmd_t         cmd
);
    logic do_wr;
    assign do_wr = op_valid & op_write;

    always_comb begin
        cmd.wr_cur  = do_wr & ~op_saved;
        cmd.wr_sav  = do_wr & op_saved;
        cmd.flag_en = instr[B_FLAG_EN];
        cmd.ctrl_en = instr[B_CTRL_EN];
        cmd.user    = priv_user;
    end
endmodule

// File: rtl/sr_operand_sel.sv
module sr_operand_sel
    import stat_reg_pkg::*;
(
    input  logic [SR_W-1:0]  instr,
    input  logic [SR_W-1:0]  reg_operand,
    output logic [IDX_W-1:0] src_index,
    output logic [SR_W-1:0]  wdata
);
    assign src_index = instr[IDX_W-1:0];

    always_comb begin
        if (instr[B_IMM_FORM])
            wdata = rot_imm(instr[IMM_W-1:0], instr[IMM_W+ROT_W-1:IMM_W]);
        else
            wdata = reg_operand;
    end
endmodule

// File: rtl/sr_merge.sv
module sr_merge
    import stat_reg_pkg::*;
(
    input  sr_cmd_t         cmd,
    input  logic [SR_W-1:0] wdata,
    input  logic [SR_W-1:0] cur_q,
    input  logic [SR_W-1:0] sav_q,
    output logic [SR_W-1:0] cur_d,
    output logic [SR_W-1:0] sav_d
);
    logic [SR_W-1:0] cm, sm;
    logic            mode_wr;

    assign cm      = cur_mask(cmd);
    assign sm      = sav_mask(cmd);
    assign mode_wr = cmd.ctrl_en & ~cmd.user;

    always_comb begin
        cur_d = cur_q;
        if (cmd.wr_cur) begin
            cur_d = (cur_q & ~cm) | (wdata & cm);
            if (mode_wr) cur_d = cur_d | M_MODE4;
        end
    end

    always_comb begin
        sav_d = sav_q;
        if (cmd.wr_sav)
            sav_d = (sav_q & ~sm) | (wdata & sm) | M_MODE4;
    end
endmodule

// File: rtl/stat_reg_ctrl.sv
module stat_reg_ctrl
    import stat_reg_pkg::*;
#(
    parameter logic [SR_W-1:0] CUR_RESET = 32'h0000_00D3,
    parameter logic [SR_W-1:0] SAV_RESET = 32'h0000_0010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic             op_write,
    input  logic             op_saved,
    input  logic             priv_user,
    input  logic [SR_W-1:0]  instr,
    input  logic [SR_W-1:0]  reg_operand,
    output logic [IDX_W-1:0] src_index,
    output logic [SR_W-1:0]  cur_q,
    output logic [SR_W-1:0]  sav_q,
    output logic [SR_W-1:0]  rd_data,
    output logic             refetch
);
    sr_cmd_t         cmd;
    logic [SR_W-1:0] wdata, cur_d, sav_d;

    sr_decode u_dec (
        .op_valid (op_valid),
        .op_write (op_write),
        .op_saved (op_saved),
        .priv_user(priv_user),
        .instr    (instr),
        .cmd      (cmd)
    );

    sr_operand_sel u_opnd (
        .instr      (instr),
        .reg_operand(reg_operand),
        .src_index  (src_index),
        .wdata      (wdata)
    );

    sr_merge u_merge (
        .cmd  (cmd),
        .wdata(wdata),
        .cur_q(cur_q),
        .sav_q(sav_q),
        .cur_d(cur_d),
        .sav_d(sav_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= CUR_RESET;
            sav_q   <= SAV_RESET;
            refetch <= 1'b0;
        end else begin
            cur_q   <= cur_d;
            sav_q   <= sav_d;
            refetch <= cmd.wr_cur;
        end
    end

    assign rd_data = op_saved ? sav_q : cur_q;
endmodule

// File: rtl/stat_reg_ctrl_chk.sv
module stat_reg_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic        op_write,
    input logic        op_saved,
    input logic        priv_user,
    input logic [31:0] instr,
    input logic [31:0] cur_q,
    input logic [31:0] sav_q,
    input logic        refetch
);
    logic cw, sw;
    assign cw = op_valid && op_write && !op_saved;
    assign sw = op_valid && op_write && op_saved;

    a_r9_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
        cw |=> refetch);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !cw |=> !refetch);
    a_r6_mode_bit4: assert property (@(posedge clk) disable iff (rst)
        cur_q[4]);
    a_r6_user_guard: assert property (@(posedge clk) disable iff (rst)
        (cw && priv_user) |=> $stable({cur_q[7:6], cur_q[3:0]}));
    a_r4_mid_fixed: assert property (@(posedge clk) disable iff (rst)
        $stable(cur_q[27:8]));
    a_r3_no_field: assert property (@(posedge clk) disable iff (rst)
        (cw && !instr[19] && !instr[16]) |=> $stable(cur_q));
    a_r7_sav_bit4: assert property (@(posedge clk) disable iff (rst)
        sw |=> sav_q[4]);
    a_r10_cur_hold: assert property (@(posedge clk) disable iff (rst)
        !cw |=> $stable(cur_q));
    a_r10_sav_hold: assert property (@(posedge clk) disable iff (rst)
        !sw |=> $stable(sav_q));
endmodule

bind stat_reg_ctrl stat_reg_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_write (op_write),
    .op_saved (op_saved),
    .priv_user(priv_user),
    .instr    (instr),
    .cur_q    (cur_q),
    .sav_q    (sav_q),
    .refetch  (refetch)
);

// File: tb/sim_stat_reg_ctrl.sv
`timescale 1ns/1ps
module sim_stat_reg_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 0, op_write = 0, op_saved = 0, priv_user = 0;
    logic [31:0] instr = 0, reg_operand = 0;
    logic [3:0]  src_index;
    logic [31:0] cur_q, sav_q, rd_data;
    logic        refetch;

    int checks = 0, failures = 0;
    string tag = "R10";

    always #5 clk = ~clk;

    stat_reg_ctrl u0 (.*);

    // behavioural reference
    logic [31:0] m_cur, m_sav;
    logic        m_ref;

    function automatic logic [31:0] m_operand(input logic [31:0] i, input logic [31:0] r);
        logic [31:0] v;
        if (!i[25]) return r;
        v = {24'd0, i[7:0]};
        for (int k = 0; k < 2 * i[11:8]; k++) v = {v[0], v[31:1]};
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cur <= 32'h0000_00D3; m_sav <= 32'h0000_0010; m_ref <= 0;
        end else begin
            logic [31:0] d, c, s;
            d = m_operand(instr, reg_operand);
            c = m_cur; s = m_sav;
            if (op_valid && op_write && !op_saved) begin
                if (instr[19]) c[31:28] = d[31:28];
                if (instr[16]) begin
                    c[5] = d[5];
                    if (!priv_user) begin
                        c[7:6] = d[7:6]; c[3:0] = d[3:0]; c[4] = 1'b1;
                    end
                end
            end
            if (op_valid && op_write && op_saved) begin
                if (instr[19]) s[31:28] = d[31:28];
                if (instr[16]) begin s[7:5] = d[7:5]; s[3:0] = d[3:0]; end
                s[4] = 1'b1;
            end
            m_cur <= c; m_sav <= s;
            m_ref <= op_valid && op_write && !op_saved;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always begin
        @(negedge clk); #1;
        if (!rst) begin
            chk({tag, " cur"}, cur_q, m_cur);
            chk({tag, " sav"}, sav_q, m_sav);
            chk({tag, " refetch"}, {31'd0, refetch}, {31'd0, m_ref});
            chk("R8 rd_data", rd_data, op_saved ? m_sav : m_cur);
            chk("R2 src_index", {28'd0, src_index}, {28'd0, instr[3:0]});
        end
    end

    task automatic op(input logic w, input logic s, input logic u,
                      input logic [31:0] i, input logic [31:0] r);
        @(negedge clk);
        op_valid = 1; op_write = w; op_saved = s; priv_user = u;
        instr = i; reg_operand = r;
        @(negedge clk);
        op_valid = 0;
        #2;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #2;
        tag = "R1";
        chk("R1 reset cur", cur_q, 32'h0000_00D3);
        chk("R1 reset sav", sav_q, 32'h0000_0010);
        chk("R1 reset refetch", {31'd0, refetch}, 32'd0);

        tag = "R2";
        op(1, 0, 0, 32'h0208_04F0, 0);                  // imm 0xF0 ror 8
        chk("R2 imm rotate", cur_q, 32'hF000_00D3);
        chk("R9 pulse", {31'd0, refetch}, 32'd1);
        @(negedge clk); #2;
        chk("R9 single cycle", {31'd0, refetch}, 32'd0);
        op(1, 0, 0, 32'h0008_0000, 32'h5A5A_5A5A);      // register form
        chk("R2 reg form", cur_q, 32'h5000_00D3);
        op(1, 0, 0, 32'h0209_0F02, 0);                  // 0x02 ror 30 -> 0x08
        chk("R2 max rotate", cur_q, 32'h0000_0018);

        tag = "R4";
        op(1, 0, 0, 32'h0008_0000, 32'hFFFF_FFFF);
        chk("R4 flags only", cur_q, 32'hF000_0018);

        tag = "R3";
        op(1, 0, 0, 32'h0006_FFFF, 32'h0000_0000);
        chk("R3 ignored fields", cur_q, 32'hF000_0018);
        chk("R9 pulse no field", {31'd0, refetch}, 32'd1);

        tag = "R6";
        op(1, 0, 0, 32'h0001_0000, 32'h0000_00FF);
        chk("R6 priv ctrl", cur_q, 32'hF000_00FF);
        op(1, 0, 0, 32'h0001_0000, 32'h0000_0000);
        chk("R6 mode bit4 forced", cur_q, 32'hF000_0010);

        tag = "R5";
        op(1, 0, 1, 32'h0001_0000, 32'h0000_00EF);
        chk("R5 user state bit", cur_q, 32'hF000_0030);

        tag = "R7";
        op(1, 1, 1, 32'h0009_0000, 32'hFFFF_FFFF);
        chk("R7 sav full", sav_q, 32'hF000_00FF);
        chk("R9 no pulse on sav", {31'd0, refetch}, 32'd0);
        op(1, 1, 0, 32'h0001_0000, 32'h0000_0000);
        chk("R7 sav ctrl", sav_q, 32'hF000_0010);
        op(1, 1, 0, 32'h0000_0000, 32'h0000_0000);
        chk("R7 sav no field", sav_q, 32'hF000_0010);

        tag = "R8";
        op_saved = 1; #1;
        chk("R8 read sav", rd_data, 32'hF000_0010);
        op_saved = 0; #1;
        chk("R8 read cur", rd_data, 32'hF000_0030);

        tag = "R10";
        op(0, 0, 0, 32'h0009_0000, 32'hFFFF_FFFF);
        chk("R10 read no change", cur_q, 32'hF000_0030);

        tag = "R10 random";
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            op_valid    = $urandom_range(0, 3) != 0;
            op_write    = $urandom_range(0, 3) != 0;
            op_saved    = $urandom_range(0, 2) == 0;
            priv_user   = $urandom_range(0, 1);
            instr       = $urandom;
            reg_operand = $urandom;
        end
        @(negedge clk);
        op_valid = 0;
        repeat (2) @(negedge clk);
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule